// File: doc/BRIEF.md
# Vectored Interrupt Entry Unit

This unit performs the processor-side entry sequence for an interrupt that an external interrupt controller has already chosen. The controller presents a handler address, a target register set, an interrupt level and a non-maskable flag. When the core accepts the request, the unit builds the new status word. It saves the interrupted context either in the exception-status register or in the saved-status slot of the chosen shadow register set. It writes the return address into that set and redirects the program counter to the handler.

The unit owns the status, exception-status and program-counter registers. The shadow register file sits outside the unit and is written through two write ports: one for the saved-status slot and one for the return-address slot. While the unit is idle, the core can load the status word and PC through a context-load port.

Top module: `irq_entry_unit`

## Requirements
- R1: On entry, status bits [15:10] (current set) take the requested set, bits [9:4] (level) take the requested level, and bit 22 (non-maskable) takes the requested flag.
- R2: On entry, bit 0 (user mode) and bit 23 (set-interrupt enable) are cleared, bit 3 (handler active) is set, and bit 2 (exception active) keeps its old value.
- R3: If the old bit 2 is 0, status bits [21:16] (previous set) receive the old bits [15:10]. Otherwise those bits are unchanged.
- R4: If the old bit 2 is 0 and the requested set is 0, the exception-status register receives the old status and no saved-status write occurs.
- R5: If the old bit 2 is 0 and the requested set is nonzero, the saved-status slot of that set receives the old status, with bit 31 ORed in when the requested set differs from the old current set. The exception-status register is unchanged.
- R6: If the old bit 2 is 0, the return-address slot of the requested set receives PC + 4. If it is 1, no shadow write occurs and the exception-status register is unchanged.
- R7: After entry, the PC equals the requested handler address.
- R8: A requested set of NUM_SETS or more raises set_err together with done. Status, PC and exception status are left untouched and no shadow write occurs.
- R9: A request is taken only while busy is low. Busy is high for exactly the one cycle after acceptance, and requests during that cycle are ignored. Done pulses for one cycle starting at the edge that ends busy, and the register updates land on that same edge.
- R10: After reset, status and exception status are 0, the PC is RESET_PC, and busy, done and set_err are 0.
- R11: While idle with acc low, ctx_load loads status from ctx_status and the PC from ctx_pc at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc | input | 1 | Accept strobe for the presented request |
| req_handler | input | 32 | Requested handler address |
| req_set | input | 6 | Requested register set |
| req_level | input | 6 | Requested interrupt level |
| req_nmi | input | 1 | Requested non-maskable flag |
| ctx_load | input | 1 | Load status and PC while idle |
| ctx_status | input | 32 | Status value to load |
| ctx_pc | input | 32 | PC value to load |
| status_o | output | 32 | Current status word |
| estatus_o | output | 32 | Exception-status register |
| pc_o | output | 32 | Program counter |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle completion pulse |
| set_err | output | 1 | Requested set out of range, with done |
| sst_we | output | 1 | Saved-status slot write enable |
| sst_set | output | 6 | Saved-status slot set index |
| sst_data | output | 32 | Saved-status slot data |
| ea_we | output | 1 | Return-address slot write enable |
| ea_set | output | 6 | Return-address slot set index |
| ea_data | output | 32 | Return-address data |

## Verification
Acceptance happens on the edge where acc is sampled while idle. The shadow writes are driven during the following busy cycle and land at the next edge. Status, PC, exception status, done and set_err change on that same second edge, and a context load lands one edge after it is presented. The bench model advances on each rising edge with exactly this latency. Every output and every shadow slot is compared a short delay after the edge, so each result is checked in the cycle it is due and never before.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int XLEN   = 32;
  localparam int SET_W  = 6;
  localparam int LVL_W  = 6;

  localparam int B_UM     = 0;
  localparam int B_EH     = 2;
  localparam int B_IH     = 3;
  localparam int B_IL_LO  = 4;
  localparam int B_CRS_LO = 10;
  localparam int B_PRS_LO = 16;
  localparam int B_NMI    = 22;
  localparam int B_RSIE   = 23;
  localparam int B_SRS    = 31;

  typedef struct packed {
    logic [XLEN-1:0]  handler;
    logic [SET_W-1:0] set;
    logic [LVL_W-1:0] lvl;
    logic             nmi;
  } irq_req_t;

  function automatic logic [XLEN-1:0] f_entry_status(
    input logic [XLEN-1:0]  old,
    input logic [SET_W-1:0] set,
    input logic [LVL_W-1:0] lvl,
    input logic             nmi
  );
    logic [XLEN-1:0] s;
    s = old;
    s[B_CRS_LO +: SET_W] = set;
    s[B_IL_LO +: LVL_W]  = lvl;
    s[B_NMI]  = nmi;
    s[B_RSIE] = 1'b0;
    s[B_UM]   = 1'b0;
    s[B_IH]   = 1'b1;
    if (!old[B_EH]) s[B_PRS_LO +: SET_W] = old[B_CRS_LO +: SET_W];
    return s;
  endfunction

  function automatic logic [XLEN-1:0] f_saved_copy(
    input logic [XLEN-1:0]  old,
    input logic [SET_W-1:0] set
  );
    logic [XLEN-1:0] c;
    c = old;
    if (set != old[B_CRS_LO +: SET_W]) c[B_SRS] = 1'b1;
    return c;
  endfunction

  function automatic logic f_in_range(input logic [SET_W-1:0] set, input int n);
    return (32'(set) < 32'(n));
  endfunction
endpackage

// File: rtl/irq_entry_calc.sv
module irq_entry_calc
  import irq_entry_pkg::*;
#(
  parameter int NUM_SETS = 8
) (
  input  logic [XLEN-1:0]  old_status,
  input  logic [SET_W-1:0] set,
  input  logic [LVL_W-1:0] lvl,
  input  logic             nmi,
  output logic [XLEN-1:0]  new_status,
  output logic [XLEN-1:0]  saved_copy,
  output logic             in_range,
  output logic             to_estatus,
  output logic             to_slot,
  output logic             wr_ret
);
  logic eh_w;
  logic set_zero_w;

  assign eh_w       = old_status[B_EH];
  assign set_zero_w = (set == '0);
  assign in_range   = f_in_range(set, NUM_SETS);
  assign new_status = f_entry_status(old_status, set, lvl, nmi);
  assign saved_copy = f_saved_copy(old_status, set);
  assign wr_ret     = in_range && !eh_w;
  assign to_estatus = wr_ret && set_zero_w;
  assign to_slot    = wr_ret && !set_zero_w;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc,
  input  irq_req_t req_in,
  output logic     busy,
  output logic     take,
  output irq_req_t req_cap
);
  typedef enum logic {ST_IDLE = 1'b0, ST_APPLY = 1'b1} st_t;
  st_t state_q;

  assign busy = (state_q == ST_APPLY);
  assign take = acc && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_cap <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_APPLY;
          req_cap <= req_in;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int          NUM_SETS = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic [31:0] req_handler,
  input  logic [5:0]  req_set,
  input  logic [5:0]  req_level,
  input  logic        req_nmi,
  input  logic        ctx_load,
  input  logic [31:0] ctx_status,
  input  logic [31:0] ctx_pc,
  output logic [31:0] status_o,
  output logic [31:0] estatus_o,
  output logic [31:0] pc_o,
  output logic        busy,
  output logic        done,
  output logic        set_err,
  output logic        sst_we,
  output logic [5:0]  sst_set,
  output logic [31:0] sst_data,
  output logic        ea_we,
  output logic [5:0]  ea_set,
  output logic [31:0] ea_data
);
  irq_req_t req_in_w, req_cap_w;
  logic     take_w;
  logic [XLEN-1:0] new_status_w, saved_copy_w;
  logic in_range_w, to_estatus_w, to_slot_w, wr_ret_w;
  logic apply_ok_w, ctx_take_w;

  assign req_in_w = '{handler: req_handler, set: req_set, lvl: req_level, nmi: req_nmi};

  irq_entry_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .req_in  (req_in_w),
    .busy    (busy),
    .take    (take_w),
    .req_cap (req_cap_w)
  );

  irq_entry_calc #(.NUM_SETS(NUM_SETS)) u_calc (
    .old_status (status_o),
    .set        (req_cap_w.set),
    .lvl        (req_cap_w.lvl),
    .nmi        (req_cap_w.nmi),
    .new_status (new_status_w),
    .saved_copy (saved_copy_w),
    .in_range   (in_range_w),
    .to_estatus (to_estatus_w),
    .to_slot    (to_slot_w),
    .wr_ret     (wr_ret_w)
  );

  assign apply_ok_w = busy && in_range_w;
  assign ctx_take_w = !busy && !take_w && ctx_load;

  assign sst_we   = busy && to_slot_w;
  assign sst_set  = req_cap_w.set;
  assign sst_data = saved_copy_w;
  assign ea_we    = busy && wr_ret_w;
  assign ea_set   = req_cap_w.set;
  assign ea_data  = pc_o + 32'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o  <= '0;
      estatus_o <= '0;
      pc_o      <= RESET_PC;
      done      <= 1'b0;
      set_err   <= 1'b0;
    end else begin
      done    <= busy;
      set_err <= busy && !in_range_w;
      if (apply_ok_w) begin
        status_o <= new_status_w;
        pc_o     <= req_cap_w.handler;
        if (to_estatus_w) estatus_o <= status_o;
      end else if (ctx_take_w) begin
        status_o <= ctx_status;
        pc_o     <= ctx_pc;
      end
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int NUM_SETS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] req_handler,
  input logic        busy,
  input logic        done,
  input logic        set_err,
  input logic [31:0] status_o,
  input logic [31:0] estatus_o,
  input logic [31:0] pc_o,
  input logic        sst_we,
  input logic [5:0]  sst_set,
  input logic        ea_we
);
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy); // R9
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) set_err |-> done); // R8
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |-> $stable(status_o) && $stable(pc_o) && $stable(estatus_o)); // R8
  AST_PC_TO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !set_err) |-> pc_o == $past(req_handler, 2)); // R7
  AST_HANDLER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !set_err) |-> status_o[3]); // R2
  AST_SLOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) sst_we |-> sst_set != 6'd0); // R5
  AST_EH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && status_o[2]) |-> !sst_we && !ea_we); // R6
  AST_WRITES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sst_we |-> 32'(sst_set) < 32'(NUM_SETS)); // R8
endmodule

bind irq_entry_unit irq_entry_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_handler (req_handler),
  .busy        (busy),
  .done        (done),
  .set_err     (set_err),
  .status_o    (status_o),
  .estatus_o   (estatus_o),
  .pc_o        (pc_o),
  .sst_we      (sst_we),
  .sst_set     (sst_set),
  .ea_we       (ea_we)
);

// File: tb/sim_irq_entry_unit.sv
`timescale 1ns/1ps
module sim_irq_entry_unit;
  localparam int NS = 8;
  localparam logic [31:0] RPC = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 0, req_nmi = 0, ctx_load = 0;
  logic [31:0] req_handler = 0, ctx_status = 0, ctx_pc = 0;
  logic [5:0]  req_set = 0, req_level = 0;
  logic [31:0] status_o, estatus_o, pc_o, sst_data, ea_data;
  logic busy, done, set_err, sst_we, ea_we;
  logic [5:0] sst_set, ea_set;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_entry_unit #(.NUM_SETS(NS), .RESET_PC(RPC)) u0 (.*);

  logic [31:0] sh_st [NS];
  logic [31:0] sh_ea [NS];
  initial for (int i = 0; i < NS; i++) begin sh_st[i] = 0; sh_ea[i] = 0; end
  always @(posedge clk) begin
    if (sst_we && sst_set < NS) sh_st[sst_set] <= sst_data;
    if (ea_we && ea_set < NS) sh_ea[ea_set] <= ea_data;
  end

  // behavioural reference
  logic [31:0] m_st = 0, m_est = 0, m_pc = RPC;
  logic m_busy = 0, m_done = 0, m_err = 0;
  logic [31:0] m_sst [NS];
  logic [31:0] m_sea [NS];
  logic [31:0] c_h; integer c_set, c_lvl; logic c_nmi;
  initial for (int i = 0; i < NS; i++) begin m_sst[i] = 0; m_sea[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_est = 0; m_pc = RPC; m_busy = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        m_busy = 0; m_done = 1;
        if (c_set >= NS) m_err = 1;
        else begin
          logic [31:0] old, ns; integer ocrs;
          old = m_st; ocrs = (old >> 10) & 63;
          ns = old & ~((32'h3F << 10) | (32'h3F << 4) | (32'h1 << 22) | (32'h1 << 23) | 32'h1);
          ns = ns | (32'(c_set) << 10) | (32'(c_lvl) << 4) | (32'(c_nmi) << 22) | 32'h8;
          if (old[2] == 1'b0) begin
            ns = (ns & ~(32'h3F << 16)) | (32'(ocrs) << 16);
            if (c_set == 0) m_est = old;
            else m_sst[c_set] = (c_set != ocrs) ? (old | 32'h8000_0000) : old;
            m_sea[c_set] = m_pc + 4;
          end
          m_st = ns; m_pc = c_h;
        end
      end else if (acc) begin
        m_busy = 1; c_h = req_handler; c_set = req_set; c_lvl = req_level; c_nmi = req_nmi;
      end else if (ctx_load) begin
        m_st = ctx_status; m_pc = ctx_pc;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n && !finished) begin
    #2;
    chk("R1 R2 R3 R11 status", status_o, m_st);
    chk("R4 estatus", estatus_o, m_est);
    chk("R7 R11 pc", pc_o, m_pc);
    chk("R9 busy", 32'(busy), 32'(m_busy));
    chk("R9 done", 32'(done), 32'(m_done));
    chk("R8 set_err", 32'(set_err), 32'(m_err));
    for (int i = 0; i < NS; i++) begin
      chk("R5 saved-status slot", sh_st[i], m_sst[i]);
      chk("R6 return-address slot", sh_ea[i], m_sea[i]);
    end
  end

  task automatic load_ctx(input logic [31:0] st, input logic [31:0] pc);
    @(negedge clk); ctx_load = 1; ctx_status = st; ctx_pc = pc;
    @(negedge clk); ctx_load = 0;
  endtask

  task automatic fire(input logic [31:0] h, input logic [5:0] s, input logic [5:0] l,
                      input logic n, input int hold);
    @(negedge clk); acc = 1; req_handler = h; req_set = s; req_level = l; req_nmi = n;
    repeat (hold) @(negedge clk);
    acc = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 status", status_o, 0);
    chk("R10 pc", pc_o, RPC);
    chk("R10 flags", {29'd0, busy, done, set_err}, 0);
    rst_n = 1;
    load_ctx(32'h0000_0001, 32'h0000_1000);            // R11
    @(negedge clk); chk("R11 loaded pc", pc_o, 32'h1000);
    fire(32'h0000_2000, 6'd0, 6'd5, 1'b0, 1);          // R4: set 0 -> estatus
    chk("R4 estatus", estatus_o, 32'h0000_0001);
    chk("R7 pc", pc_o, 32'h2000);
    chk("R1 R2 status", status_o, 32'h0000_0058);
    load_ctx(32'h0080_0801, 32'h0000_3000);            // crs=2, UM, RSIE
    fire(32'h0000_4000, 6'd3, 6'd9, 1'b0, 1);          // R5: switch set
    chk("R5 saved slot with switch flag", sh_st[3], 32'h8080_0801);
    chk("R6 return address", sh_ea[3], 32'h3004);
    chk("R3 previous set", {26'd0, status_o[21:16]}, 2);
    fire(32'h0000_5000, 6'd3, 6'd1, 1'b1, 1);          // same set, NMI
    chk("R5 saved slot no switch", sh_st[3][31], 0);
    chk("R1 nmi bit", {31'd0, status_o[22]}, 1);
    load_ctx(32'h0000_1C04, 32'h0000_6000);            // EH=1, crs=7
    fire(32'h0000_7000, 6'd5, 6'd63, 1'b1, 1);         // R6: no writes
    chk("R6 no write under EH", sh_ea[5], 0);
    chk("R3 prev unchanged under EH", {26'd0, status_o[21:16]}, 0);
    fire(32'h0000_8000, 6'd9, 6'd2, 1'b0, 1);          // R8
    chk("R8 pc untouched", pc_o, 32'h7000);
    load_ctx(32'h0000_0800, 32'h0000_9000);            // crs=2
    fire(32'h0000_A000, 6'd1, 6'd4, 1'b0, 3);          // R9: acc held through busy
    fire(32'h0000_B000, 6'd9, 6'd0, 1'b0, 2);          // R8 + R9 back to back
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule